// File: doc/BRIEF.md
# Complex NCO Quadrature Upconverter

This block shifts a complex baseband stream up to a digital carrier. A 32-bit phase accumulator advances by a programmable tuning word on every clock. A separate offset word is added to the running phase, and the top bits of that sum select cosine and sine values from a quarter-wave table. Each input pair (I, Q) is rotated by the carrier: the in-phase output is I·cos − Q·sin and the quadrature output is I·sin + Q·cos. Both are rounded and saturated back to 16-bit signed samples.

Software-side writes go through a small register port that holds the tuning word, the offset word and a control word. The tuning and offset words are double-buffered. In immediate mode a write reaches the datapath at once. In hold mode writes collect in shadow copies, and a single update strobe moves all of them into the datapath together. A three-state machine tracks the buffering mode. LIVE is immediate mode. HELD is hold mode with nothing waiting. ARMED is hold mode with a shadow write waiting. Its transitions are:
- LIVE→HELD when the hold bit is set.
- HELD→ARMED on a tuning or offset write without a strobe.
- ARMED→HELD on the strobe.
- HELD or ARMED→LIVE when the hold bit is cleared, which also flushes the shadow copies.

A control bit bypasses the rotation so that samples pass through with the same latency. Another control bit keeps the accumulator at zero.

Top module: `nco_quad_mixer`

## Requirements
- R1: The synchronous active-high reset sets the outputs to zero and sets the accumulator, tuning word, offset word and control word to zero. After reset the block is in bypass with immediate updates.
- R2: On every clock that is not in reset, the accumulator adds the active tuning word modulo 2^32.
- R3: The phase used for a sample is the accumulator plus the active offset word modulo 2^32. Its top 10 bits form the table phase p.
- R4: The sine for p is round(32767·sin(2π(p+0.5)/1024)). The cosine is the sine of (p+256) mod 1024. Rounding is to the nearest integer, with ties away from zero.
- R5: When modulation is on, the in-phase output is (I·cos − Q·sin + 2^14) >> 15 and the quadrature output is (I·sin + Q·cos + 2^14) >> 15. Both shifts are arithmetic, and each result is clamped to [−32768, 32767].
- R6: A sample presented at clock edge n appears on the outputs after edge n+2, in both modulation and bypass.
- R7: When control bit 0 (modulation enable) is 0, the outputs equal the inputs unchanged.
- R8: While control bit 1 (accumulator clear) is 1, the accumulator is zero after every clock edge.
- R9: The register addresses are 0 for the tuning word, 1 for the offset word and 2 for the control word. The control bits are bit 0 enable, bit 1 clear and bit 2 hold. A control write takes effect from the next edge. In immediate mode (bit 2 = 0), a tuning or offset write becomes active at the edge that captures it.
- R10: In hold mode, tuning and offset writes change nothing in the datapath until the update strobe. At the strobe, every shadow value becomes active together, including a write captured at the same edge.
- R11: A control write that clears the hold bit makes all pending shadow values active at that edge.
- R12: A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address (0 tuning, 1 offset, 2 control) |
| cfg_wdata | input | 32 | Register write data |
| upd_strobe | input | 1 | Applies all shadow settings in hold mode |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| out_i | output | 16 | In-phase output sample, signed |
| out_q | output | 16 | Quadrature output sample, signed |

## Verification
Constant I/Q inputs with a zero tuning word and offset words spread over all eight octants isolate the table fold and quadrant sign handling from the accumulator. Pseudo-random and ramp inputs under positive and wrapping tuning words separate a correct rotation from swapped sine/cosine or sign errors. Full-scale equal and opposite inputs at a 45-degree phase force both saturation limits. Step inputs in bypass pin down the exact latency, and each buffering transition is driven with the data still streaming.

// File: rtl/nqm_pkg.sv
`timescale 1ns/1ps
package nqm_pkg;

    typedef enum logic [1:0] {
        ST_LIVE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_ARMED = 2'd2
    } hold_state_e;

    // control word: bit 0 enable, bit 1 clear, bit 2 hold
    typedef struct packed {
        logic hold;
        logic clr;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] REG_TUNE = 2'd0;
    localparam logic [1:0] REG_OFFS = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;

    localparam real PI_R = 3.14159265358979323846;

    // One entry of the first-quadrant sine table, sampled half a step
    // off the axis so that the quadrant mirrors are exact.
    function automatic int quarter_entry(input int k, input int qdepth, input int amp);
        real ang;
        ang = PI_R * (real'(k) + 0.5) / (2.0 * real'(qdepth));
        return $rtoi(real'(amp) * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/nqm_settings.sv
`timescale 1ns/1ps
module nqm_settings #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [1:0]         addr_i,
    input  logic [PHASE_W-1:0] wdata_i,
    input  logic               upd_i,
    output logic [PHASE_W-1:0] tune_o,
    output logic [PHASE_W-1:0] offs_o,
    output logic               mod_en_o,
    output logic               acc_clr_o
);
    import nqm_pkg::*;

    hold_state_e        state, state_nx;
    ctrl_t              ctrl_q, ctrl_d;
    logic [PHASE_W-1:0] tune_sh, offs_sh, tune_sh_d, offs_sh_d;
    logic [PHASE_W-1:0] tune_act, offs_act;
    logic               wr_tune, wr_offs, wr_ctrl, load;

    always_comb begin
        wr_tune   = we_i && (addr_i == REG_TUNE);
        wr_offs   = we_i && (addr_i == REG_OFFS);
        wr_ctrl   = we_i && (addr_i == REG_CTRL);
        tune_sh_d = wr_tune ? wdata_i : tune_sh;
        offs_sh_d = wr_offs ? wdata_i : offs_sh;
        ctrl_d    = wr_ctrl ? ctrl_t'(wdata_i[CTRL_W-1:0]) : ctrl_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_LIVE;
        else     state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LIVE: begin
                if (ctrl_d.hold) state_nx = ST_HELD;
            end
            ST_HELD: begin
                if (!ctrl_d.hold)                      state_nx = ST_LIVE;
                else if (!upd_i && (wr_tune || wr_offs)) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (!ctrl_d.hold) state_nx = ST_LIVE;
                else if (upd_i)   state_nx = ST_HELD;
            end
            default: state_nx = ST_LIVE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        load = 1'b0;
        unique case (state)
            ST_LIVE:  load = 1'b1;
            ST_HELD:  load = upd_i || !ctrl_d.hold;
            ST_ARMED: load = upd_i || !ctrl_d.hold;
            default:  load = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tune_sh  <= '0;
            offs_sh  <= '0;
            tune_act <= '0;
            offs_act <= '0;
            ctrl_q   <= '0;
        end else begin
            tune_sh <= tune_sh_d;
            offs_sh <= offs_sh_d;
            ctrl_q  <= ctrl_d;
            if (load) begin
                tune_act <= tune_sh_d;
                offs_act <= offs_sh_d;
            end
        end
    end

    assign tune_o    = tune_act;
    assign offs_o    = offs_act;
    assign mod_en_o  = ctrl_q.en;
    assign acc_clr_o = ctrl_q.clr;

    // R10: while holding with no strobe and no release, the datapath settings do not move
    p_held_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_LIVE && !upd_i && ctrl_d.hold) |=> ($stable(tune_act) && $stable(offs_act)));

    // R10: the machine agrees with the hold bit of the control word
    p_mode_track_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.hold |-> (state != ST_LIVE));

    // R11: a release from hold leaves active values equal to the shadow copies
    p_release_flush_r11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_LIVE && !ctrl_d.hold) |=> (tune_act == tune_sh && offs_act == offs_sh));

endmodule

// File: rtl/nqm_phase.sv
`timescale 1ns/1ps
module nqm_phase #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic [PHASE_W-1:0] tune_i,
    input  logic [PHASE_W-1:0] offs_i,
    output logic [ADDR_W-1:0]  addr_o
);
    localparam int SHIFT = PHASE_W - ADDR_W;

    logic [PHASE_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr_i) acc <= '0;
        else              acc <= acc + tune_i;
    end

    assign addr_o = ADDR_W'((acc + offs_i) >> SHIFT);

    // R8: the clear bit pins the accumulator at zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (acc == '0));

endmodule

// File: rtl/nqm_trig.sv
`timescale 1ns/1ps
module nqm_trig #(
    parameter int ADDR_W = 10,
    parameter int TRIG_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic signed [TRIG_W-1:0] sin_o,
    output logic signed [TRIG_W-1:0] cos_o
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int QDEPTH = 2 ** IDX_W;
    localparam int AMP    = 2 ** (TRIG_W - 1) - 1;
    localparam longint MAG_NOM = longint'(AMP) * longint'(AMP);
    localparam longint MAG_TOL = longint'(AMP) * 2;

    logic signed [TRIG_W-1:0] rom [QDEPTH];

    for (genvar g = 0; g < QDEPTH; g++) begin : g_rom
        localparam int ENTRY = nqm_pkg::quarter_entry(g, QDEPTH, AMP);
        assign rom[g] = TRIG_W'(ENTRY);
    end

    // lane 0 is the sine, lane 1 the cosine (a quarter turn ahead)
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic [1:0]               quad;
        logic [IDX_W-1:0]         idx;
        logic signed [TRIG_W-1:0] mag, val, val_q;
        always_comb begin
            quad = addr_i[ADDR_W-1 -: 2] + 2'(ln);
            idx  = addr_i[IDX_W-1:0];
            mag  = quad[0] ? rom[~idx] : rom[idx];
            val  = quad[1] ? -mag : mag;
        end
        always_ff @(posedge clk) begin
            if (rst) val_q <= '0;
            else     val_q <= val;
        end
    end

    assign sin_o = g_lane[0].val_q;
    assign cos_o = g_lane[1].val_q;

    logic primed;
    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    logic signed [2*TRIG_W+1:0] mag2;
    assign mag2 = sin_o * sin_o + cos_o * cos_o;

    // R4: the sine/cosine pair stays on the unit circle within rounding error
    p_unit_circle_r4: assert property (@(posedge clk) disable iff (rst)
        primed |-> (longint'(mag2) >= MAG_NOM - MAG_TOL && longint'(mag2) <= MAG_NOM + MAG_TOL));

endmodule

// File: rtl/nqm_mix.sv
`timescale 1ns/1ps
module nqm_mix #(
    parameter int DATA_W = 16,
    parameter int TRIG_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_i,
    input  logic signed [DATA_W-1:0] i_i,
    input  logic signed [DATA_W-1:0] q_i,
    input  logic signed [TRIG_W-1:0] sin_i,
    input  logic signed [TRIG_W-1:0] cos_i,
    output logic signed [DATA_W-1:0] i_o,
    output logic signed [DATA_W-1:0] q_o
);
    localparam int FRAC   = TRIG_W - 1;
    localparam int PROD_W = DATA_W + TRIG_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(2 ** (FRAC - 1));
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'(2 ** (DATA_W - 1) - 1);
    localparam logic signed [SUM_W-1:0] MINV = -SUM_W'(2 ** (DATA_W - 1));

    function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [SUM_W-1:0] v);
        logic signed [SUM_W-1:0] s;
        s = (v + HALF) >>> FRAC;
        if (s > MAXV)      return DATA_W'(MAXV);
        else if (s < MINV) return DATA_W'(MINV);
        else               return DATA_W'(s);
    endfunction

    logic signed [PROD_W-1:0] p_ic, p_qs, p_is, p_qc;
    logic signed [SUM_W-1:0]  sum_i, sum_q;
    logic signed [DATA_W-1:0] rot_i, rot_q;

    always_comb begin
        p_ic  = i_i * cos_i;
        p_qs  = q_i * sin_i;
        p_is  = i_i * sin_i;
        p_qc  = q_i * cos_i;
        sum_i = SUM_W'(p_ic) - SUM_W'(p_qs);
        sum_q = SUM_W'(p_is) + SUM_W'(p_qc);
        rot_i = round_sat(sum_i);
        rot_q = round_sat(sum_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            i_o <= '0;
            q_o <= '0;
        end else if (en_i) begin
            i_o <= rot_i;
            q_o <= rot_q;
        end else begin
            i_o <= i_i;
            q_o <= q_i;
        end
    end

    // R5: saturation never lets a large positive sum appear as a negative output
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (en_i && sum_q > (MAXV <<< FRAC)) |=> (q_o == DATA_W'(MAXV)));

endmodule

// File: rtl/nco_quad_mixer.sv
`timescale 1ns/1ps
module nco_quad_mixer #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16,
    parameter int TRIG_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_addr,
    input  logic [PHASE_W-1:0]       cfg_wdata,
    input  logic                     upd_strobe,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q
);
    logic [PHASE_W-1:0]       tune, offs;
    logic                     mod_en, acc_clr;
    logic [ADDR_W-1:0]        addr_c, addr_s1;
    logic signed [DATA_W-1:0] i_s1, q_s1, i_s2, q_s2;
    logic                     en_s1, en_s2;
    logic signed [TRIG_W-1:0] sin_s2, cos_s2;

    nqm_settings #(.PHASE_W(PHASE_W)) u_settings (
        .clk       (clk),
        .rst       (rst),
        .we_i      (cfg_we),
        .addr_i    (cfg_addr),
        .wdata_i   (cfg_wdata),
        .upd_i     (upd_strobe),
        .tune_o    (tune),
        .offs_o    (offs),
        .mod_en_o  (mod_en),
        .acc_clr_o (acc_clr)
    );

    nqm_phase #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (acc_clr),
        .tune_i (tune),
        .offs_i (offs),
        .addr_o (addr_c)
    );

    // stage 1: capture sample, mode and table phase
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_s1 <= '0;
            i_s1    <= '0;
            q_s1    <= '0;
            en_s1   <= 1'b0;
        end else begin
            addr_s1 <= addr_c;
            i_s1    <= in_i;
            q_s1    <= in_q;
            en_s1   <= mod_en;
        end
    end

    // stage 2: table lookup, sample carried alongside
    nqm_trig #(.ADDR_W(ADDR_W), .TRIG_W(TRIG_W)) u_trig (
        .clk    (clk),
        .rst    (rst),
        .addr_i (addr_s1),
        .sin_o  (sin_s2),
        .cos_o  (cos_s2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            i_s2  <= '0;
            q_s2  <= '0;
            en_s2 <= 1'b0;
        end else begin
            i_s2  <= i_s1;
            q_s2  <= q_s1;
            en_s2 <= en_s1;
        end
    end

    // stage 3: rotate or bypass
    nqm_mix #(.DATA_W(DATA_W), .TRIG_W(TRIG_W)) u_mix (
        .clk   (clk),
        .rst   (rst),
        .en_i  (en_s2),
        .i_i   (i_s2),
        .q_i   (q_s2),
        .sin_i (sin_s2),
        .cos_i (cos_s2),
        .i_o   (out_i),
        .q_o   (out_q)
    );

    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)               warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R7 and R6: in bypass, the sample taken three edges back reaches the outputs unchanged
    p_bypass_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && !$past(mod_en, 3)) |->
            (out_i == $past(in_i, 3) && out_q == $past(in_q, 3)));

    // R1: outputs are zero right after a reset edge
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (out_i == '0 && out_q == '0));

endmodule

// File: tb/nco_quad_mixer_test.sv
`timescale 1ns/1ps
module nco_quad_mixer_test;

    localparam time CYC = 5ns;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_addr = '0;
    logic [31:0]        cfg_wdata = '0;
    logic               upd_strobe = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic signed [15:0] out_i, out_q;

    always #(CYC / 2) clk = ~clk;

    nco_quad_mixer uut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .upd_strobe (upd_strobe),
        .in_i       (in_i),
        .in_q       (in_q),
        .out_i      (out_i),
        .out_q      (out_q)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    localparam real PI_B = 3.14159265358979323846;

    function automatic int sine_ref(input int p);
        real v;
        v = 32767.0 * $sin(2.0 * PI_B * (real'(p % 1024) + 0.5) / 1024.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

    function automatic int scale_ref(input longint v);
        longint r;
        r = (v + 64'sd16384) >>> 15;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    int unsigned m_acc, m_tune, m_offs, s_tune, s_offs;
    bit          m_en, m_clr, m_hold;
    int          exp_i[$];
    int          exp_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_tune = 0; m_offs = 0; s_tune = 0; s_offs = 0;
            m_en = 0; m_clr = 0; m_hold = 0;
            exp_i.delete();
            exp_q.delete();
        end else begin
            int unsigned ph;
            int p, c, s, vi, vq;
            bit ld;
            ph = m_acc + m_offs;
            p  = int'(ph >> 22);
            s  = sine_ref(p);
            c  = sine_ref(p + 256);
            vi = int'(in_i);
            vq = int'(in_q);
            if (m_en) begin
                exp_i.push_back(scale_ref(longint'(vi) * c - longint'(vq) * s));
                exp_q.push_back(scale_ref(longint'(vi) * s + longint'(vq) * c));
            end else begin
                exp_i.push_back(vi);
                exp_q.push_back(vq);
            end
            m_acc = m_clr ? 0 : m_acc + m_tune;
            ld = !m_hold || upd_strobe || (cfg_we && cfg_addr == 2'd2 && !cfg_wdata[2]);
            if (cfg_we && cfg_addr == 2'd0) s_tune = cfg_wdata;
            if (cfg_we && cfg_addr == 2'd1) s_offs = cfg_wdata;
            if (ld) begin
                m_tune = s_tune;
                m_offs = s_offs;
            end
            if (cfg_we && cfg_addr == 2'd2) begin
                m_en   = cfg_wdata[0];
                m_clr  = cfg_wdata[1];
                m_hold = cfg_wdata[2];
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done && exp_i.size() >= 3) begin
            while (exp_i.size() > 3) begin
                void'(exp_i.pop_front());
                void'(exp_q.pop_front());
            end
            checks++;
            if (int'(out_i) != exp_i[0] || int'(out_q) != exp_q[0]) begin
                fails++;
                $display("FAIL %s: out_i/out_q got %0d/%0d expected %0d/%0d",
                         cur_req, out_i, out_q, exp_i[0], exp_q[0]);
            end
        end
    end

    // ---------------- stimulus ----------------
    int          pat = 0;       // 0 constant, 1 pseudo-random, 2 ramp
    int          c_i = 111, c_q = -222;
    int unsigned seed = 32'h1234_5678;
    int          ramp = 0;
    bit          nx_we = 0, nx_upd = 0;
    logic [1:0]  nx_addr = '0;
    logic [31:0] nx_data = '0;

    task automatic tick();
        @(negedge clk);
        case (pat)
            1: begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                in_i = seed[31:16];
                in_q = seed[15:0];
            end
            2: begin
                ramp = ramp + 1237;
                in_i = 16'(ramp);
                in_q = 16'(-3 * ramp);
            end
            default: begin
                in_i = 16'(c_i);
                in_q = 16'(c_q);
            end
        endcase
        cfg_we     = nx_we;
        cfg_addr   = nx_addr;
        cfg_wdata  = nx_data;
        upd_strobe = nx_upd;
        nx_we  = 0;
        nx_upd = 0;
    endtask

    task automatic run(input int n);
        repeat (n) tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit strobe);
        nx_we = 1; nx_addr = a; nx_data = d; nx_upd = strobe;
        tick();
    endtask

    task automatic strobe_only();
        nx_upd = 1;
        tick();
    endtask

    initial begin
        int hold_i;
        rst = 1'b1;
        run(4);
        // R1: outputs held at zero in reset
        chk("R1", int'(out_i), 0);
        chk("R1", int'(out_q), 0);
        rst = 1'b0;

        cur_req = "R7";
        pat = 1;
        run(20);
        pat = 0; c_i = 1234; c_q = -777;
        run(4);
        chk("R7", int'(out_i), 1234);
        chk("R7", int'(out_q), -777);

        // R6: step in bypass shows after the third edge
        cur_req = "R6";
        c_i = 0; c_q = 0;
        run(4);
        c_i = 500; c_q = -500;
        tick();
        tick(); chk("R6", int'(out_i), 0);
        tick(); chk("R6", int'(out_i), 0);
        tick(); chk("R6", int'(out_i), 500);
        chk("R6", int'(out_q), -500);

        // R1: modulation on with reset settings gives phase zero
        cur_req = "R1";
        c_i = 20000; c_q = 0;
        wr(2'd2, 32'h1, 0);
        run(6);

        cur_req = "R4";
        c_i = 0; c_q = 30000;
        run(5);

        cur_req = "R3";
        c_i = 20000; c_q = -9000;
        for (int k = 0; k < 8; k++) begin
            wr(2'd1, 32'(k) << 29, 0);
            run(5);
        end
        wr(2'd1, 32'h0300_0000, 0);
        run(5);

        cur_req = "R2";
        pat = 1;
        wr(2'd0, 32'h0123_4567, 0);
        run(60);
        pat = 2;
        wr(2'd0, 32'hF000_0000, 0);
        run(40);

        cur_req = "R9";
        pat = 1;
        wr(2'd0, 32'h0400_0000, 0);
        run(3);
        wr(2'd1, 32'h8000_0000, 0);
        run(10);

        // R5: saturation at a 45-degree carrier
        cur_req = "R5";
        pat = 0;
        wr(2'd0, 32'h0, 0);
        wr(2'd1, 32'h2000_0000, 0);
        c_i = 32767; c_q = 32767;
        run(6);
        chk("R5", int'(out_q), 32767);
        c_i = -32768; c_q = -32768;
        run(5);
        chk("R5", int'(out_q), -32768);
        c_i = 32767; c_q = -32768;
        run(5);

        // R8: clear bit freezes the phase despite a running tuning word
        cur_req = "R8";
        c_i = 10000; c_q = 3000;
        wr(2'd0, 32'h1111_1111, 0);
        wr(2'd2, 32'h3, 0);
        run(6);
        hold_i = int'(out_i);
        run(4);
        chk("R8", int'(out_i), hold_i);
        wr(2'd2, 32'h1, 0);
        pat = 1;
        run(10);

        // R10: hold mode collects writes until the strobe
        cur_req = "R10";
        wr(2'd2, 32'h5, 0);
        wr(2'd0, 32'h0770_0000, 0);
        run(8);
        wr(2'd1, 32'h4000_0000, 0);
        run(8);
        strobe_only();
        run(8);
        wr(2'd0, 32'h0033_0000, 1);
        run(8);
        strobe_only();
        run(4);

        // R11: releasing hold applies the waiting values
        cur_req = "R11";
        wr(2'd0, 32'h0200_0000, 0);
        wr(2'd1, 32'hC000_0000, 0);
        run(5);
        wr(2'd2, 32'h1, 0);
        run(10);

        // R12: address 3 is inert
        cur_req = "R12";
        wr(2'd3, 32'hFFFF_FFFF, 0);
        run(10);
        pat = 0; c_i = 4321; c_q = -1234;
        wr(2'd3, 32'h0000_0000, 0);
        run(8);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CYC * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule